// File: doc/BRIEF.md
# Boot Alias Address Decoder

This block decodes the addresses issued by a small microcontroller core on its system bus and picks which memory answers each transfer. Three memories are attached: a boot flash bank, a second flash bank and an SRAM. Each one has a fixed native region of its own. A small alias window starting at address zero sits on top of them. A core whose vector table sits at a fixed address of zero fetches its initial stack pointer, reset vector and handler addresses from that window. A two-bit mapping register decides which memory stands behind the window, so a boot loader can hand over to an image in the second bank or in SRAM. The core sees no difference: it keeps issuing the same addresses, and only the internal select and the memory offset change.

An accepted request is decoded against the mapping in force in the cycle it is accepted. The result is registered, so the select, offset and error flag appear one cycle later as a data-phase response. A mapping write lands on the same clock edge as the request it accompanies, which means it is used only by transfers accepted after that edge. Writes into the window while it shows a flash bank are answered with an error. Addresses that match nothing are answered with an error and select no memory.

Top module: `boot_alias_decoder`

## Requirements
- R1: Out of reset the mapping reads back 00 (boot flash), `rsp_valid` is 0, `tgt_sel` is 000 and `rsp_err` is 0.
- R2: With mapping 00, a request with address below `ALIAS_BYTES` (default 1024) gives `tgt_sel` = 001 (bit 0 = boot flash) and `tgt_offset` = the address.
- R3: With mapping 01, a read in the alias window gives `tgt_sel` = 010 (bit 1 = second flash bank) and `tgt_offset` = the address.
- R4: With mapping 10, both reads and writes in the alias window give `tgt_sel` = 100 (bit 2 = SRAM) and `tgt_offset` = the address, with no error.
- R5: A mapping write of 11 is ignored: the read-back value and the routing of later alias accesses are unchanged.
- R6: Outside the window the native regions decode under every mapping: boot flash at 0x0800_0000, second bank at 0x0808_0000 and SRAM at 0x2000_0000, each 512 KiB. The offset is the address minus the region base.
- R7: A write in the alias window while the mapping is 00 or 01 gives `rsp_err` = 1, `tgt_sel` = 000 and offset 0.
- R8: An address in no region gives `rsp_err` = 1, `tgt_sel` = 000 and offset 0.
- R9: The response to a request sampled at clock edge n is visible after edge n. It uses the mapping held before edge n, including when a mapping write is sampled at the same edge. The new mapping applies from the next accepted request.
- R10: Address `ALIAS_BYTES`-4 is inside the window. Address `ALIAS_BYTES` is outside it and, by default, unmapped (R8).
- R11: `tgt_sel` is one-hot or zero and never non-zero together with `rsp_err`. In a cycle after no request, `rsp_valid`, `tgt_sel` and `rsp_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A transfer is offered and accepted this cycle |
| req_addr | input | 32 | Byte address of the transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| map_wr_en | input | 1 | Write strobe for the mapping register |
| map_wr_data | input | 2 | New mapping: 00 boot flash, 01 second bank, 10 SRAM, 11 reserved |
| map_rd_data | output | 2 | Current mapping |
| rsp_valid | output | 1 | Registered decode result is present |
| tgt_sel | output | 3 | One-hot memory select: bit 0 boot flash, bit 1 second bank, bit 2 SRAM |
| tgt_offset | output | 19 | Byte offset into the selected memory |
| rsp_err | output | 1 | Error response for the transfer |

## Verification
A corrupted mapping register shows at `map_rd_data` at once and in the select of the very next alias access. A mapping write that takes effect one edge early or late sends the transfer issued alongside it to the wrong memory in the following cycle. Faults in the region compare or the window bound show up as a wrong select, a wrong offset or a missing error one cycle after the offending address. The bench therefore checks every response in the cycle it appears, against a model built from the requirements.

// File: rtl/boot_alias_pkg.sv
package boot_alias_pkg;

    localparam int N_TGT   = 3;
    localparam int OFS_W   = 19;

    localparam int TGT_BOOT = 0;
    localparam int TGT_ALT  = 1;
    localparam int TGT_SRAM = 2;

    typedef enum logic [1:0] {
        MAP_BOOT = 2'b00,
        MAP_ALT  = 2'b01,
        MAP_SRAM = 2'b10,
        MAP_RSVD = 2'b11
    } map_e;

    typedef struct packed {
        logic [N_TGT-1:0] sel;
        logic             err;
    } route_t;

    function automatic logic [N_TGT-1:0] onehot_of(input int idx);
        logic [N_TGT-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    function automatic int map_to_tgt(input map_e m);
        case (m)
            MAP_ALT:  return TGT_ALT;
            MAP_SRAM: return TGT_SRAM;
            default:  return TGT_BOOT;
        endcase
    endfunction

endpackage

// File: rtl/boot_alias_map_reg.sv
module boot_alias_map_reg
    import boot_alias_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    output map_e       map_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            map_q <= MAP_BOOT;
        end else if (wr_en && map_e'(wr_data) != MAP_RSVD) begin
            map_q <= map_e'(wr_data);
        end
    end
endmodule

// File: rtl/boot_alias_addr_decode.sv
module boot_alias_addr_decode
    import boot_alias_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int ALIAS_BYTES = 1024,
    parameter int REGION_LG   = OFS_W,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 32'h0800_0000,
    parameter logic [ADDR_W-1:0] ALT_BASE  = 32'h0808_0000,
    parameter logic [ADDR_W-1:0] SRAM_BASE = 32'h2000_0000
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 write,
    input  map_e                 map,
    output route_t               route,
    output logic [REGION_LG-1:0] offset
);
    localparam logic [ADDR_W-1:0] ALIAS_END = ADDR_W'(ALIAS_BYTES);
    localparam logic [N_TGT*ADDR_W-1:0] BASES = {SRAM_BASE, ALT_BASE, BOOT_BASE};

    logic             alias_hit;
    logic [N_TGT-1:0] native_hit;

    assign alias_hit = addr < ALIAS_END;

    for (genvar g = 0; g < N_TGT; g++) begin : g_region
        localparam logic [ADDR_W-1:0] BASE_G = BASES[g*ADDR_W +: ADDR_W];
        assign native_hit[g] = addr[ADDR_W-1:REGION_LG] == BASE_G[ADDR_W-1:REGION_LG];
    end

    always_comb begin
        route  = '0;
        offset = '0;
        if (alias_hit) begin
            if (map == MAP_SRAM) begin
                route.sel = onehot_of(TGT_SRAM);
                offset    = addr[REGION_LG-1:0];
            end else if (write) begin
                route.err = 1'b1;
            end else begin
                route.sel = onehot_of(map_to_tgt(map));
                offset    = addr[REGION_LG-1:0];
            end
        end else if (|native_hit) begin
            route.sel = native_hit;
            offset    = addr[REGION_LG-1:0];
        end else begin
            route.err = 1'b1;
        end
    end
endmodule

// File: rtl/boot_alias_resp_stage.sv
module boot_alias_resp_stage
    import boot_alias_pkg::*;
#(
    parameter int REGION_LG = OFS_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  route_t               in_route,
    input  logic [REGION_LG-1:0] in_offset,
    output logic                 out_valid,
    output route_t               out_route,
    output logic [REGION_LG-1:0] out_offset
);
    always_ff @(posedge clk) begin
        if (rst || !in_valid) begin
            out_valid  <= 1'b0;
            out_route  <= '0;
            out_offset <= '0;
        end else begin
            out_valid  <= 1'b1;
            out_route  <= in_route;
            out_offset <= in_offset;
        end
    end
endmodule

// File: rtl/boot_alias_decoder.sv
module boot_alias_decoder
    import boot_alias_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int ALIAS_BYTES = 1024,
    parameter int REGION_LG   = OFS_W,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 32'h0800_0000,
    parameter logic [ADDR_W-1:0] ALT_BASE  = 32'h0808_0000,
    parameter logic [ADDR_W-1:0] SRAM_BASE = 32'h2000_0000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_write,
    input  logic                 map_wr_en,
    input  logic [1:0]           map_wr_data,
    output logic [1:0]           map_rd_data,
    output logic                 rsp_valid,
    output logic [N_TGT-1:0]     tgt_sel,
    output logic [REGION_LG-1:0] tgt_offset,
    output logic                 rsp_err
);
    map_e                 map_q;
    route_t               dec_route;
    logic [REGION_LG-1:0] dec_offset;
    route_t               rsp_route;

    boot_alias_map_reg u_map (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (map_wr_en),
        .wr_data (map_wr_data),
        .map_q   (map_q)
    );

    boot_alias_addr_decode #(
        .ADDR_W      (ADDR_W),
        .ALIAS_BYTES (ALIAS_BYTES),
        .REGION_LG   (REGION_LG),
        .BOOT_BASE   (BOOT_BASE),
        .ALT_BASE    (ALT_BASE),
        .SRAM_BASE   (SRAM_BASE)
    ) u_dec (
        .addr   (req_addr),
        .write  (req_write),
        .map    (map_q),
        .route  (dec_route),
        .offset (dec_offset)
    );

    boot_alias_resp_stage #(
        .REGION_LG (REGION_LG)
    ) u_rsp (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (req_valid),
        .in_route   (dec_route),
        .in_offset  (dec_offset),
        .out_valid  (rsp_valid),
        .out_route  (rsp_route),
        .out_offset (tgt_offset)
    );

    assign map_rd_data = map_q;
    assign tgt_sel     = rsp_route.sel;
    assign rsp_err     = rsp_route.err;
endmodule

// File: rtl/boot_alias_decoder_chk.sv
module boot_alias_decoder_chk #(
    parameter int ADDR_W      = 32,
    parameter int ALIAS_BYTES = 1024
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_write,
    input logic              map_wr_en,
    input logic [1:0]        map_wr_data,
    input logic [1:0]        map_rd_data,
    input logic              rsp_valid,
    input logic [2:0]        tgt_sel,
    input logic              rsp_err
);
    logic in_win;
    assign in_win = req_addr < ADDR_W'(ALIAS_BYTES);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (map_rd_data == 2'b00 && !rsp_valid && tgt_sel == 3'b000 && !rsp_err)); // R1

    AST_SRAM_ALIAS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && in_win && map_rd_data == 2'b10) |=> (tgt_sel == 3'b100 && !rsp_err)); // R4

    AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (map_wr_en && map_wr_data == 2'b11) |=> $stable(map_rd_data)); // R5

    AST_FLASH_ALIAS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && in_win && req_write && map_rd_data != 2'b10) |=> (rsp_err && tgt_sel == 3'b000)); // R7

    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tgt_sel) && !(rsp_err && tgt_sel != 3'b000)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && tgt_sel == 3'b000 && !rsp_err)); // R11

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R9
endmodule

bind boot_alias_decoder boot_alias_decoder_chk #(
    .ADDR_W      (ADDR_W),
    .ALIAS_BYTES (ALIAS_BYTES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_write   (req_write),
    .map_wr_en   (map_wr_en),
    .map_wr_data (map_wr_data),
    .map_rd_data (map_rd_data),
    .rsp_valid   (rsp_valid),
    .tgt_sel     (tgt_sel),
    .rsp_err     (rsp_err)
);

// File: tb/boot_alias_decoder_bench.sv
module boot_alias_decoder_bench;

    typedef struct packed {
        logic        v;
        logic [2:0]  sel;
        logic [18:0] ofs;
        logic        err;
        logic [1:0]  map;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        map_wr_en = 1'b0;
    logic [1:0]  map_wr_data = '0;
    logic [1:0]  map_rd_data;
    logic        rsp_valid;
    logic [2:0]  tgt_sel;
    logic [18:0] tgt_offset;
    logic        rsp_err;

    int   n_checks = 0;
    int   n_fail   = 0;
    logic [1:0] model_map = 2'b00;
    exp_t  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    boot_alias_decoder u_boot_alias_decoder (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_write   (req_write),
        .map_wr_en   (map_wr_en),
        .map_wr_data (map_wr_data),
        .map_rd_data (map_rd_data),
        .rsp_valid   (rsp_valid),
        .tgt_sel     (tgt_sel),
        .tgt_offset  (tgt_offset),
        .rsp_err     (rsp_err)
    );

    function automatic exp_t predict(input logic v, input logic [31:0] a,
                                     input logic w, input logic [1:0] m);
        exp_t e;
        e = '0;
        e.v = v;
        if (!v) return e;
        if (a < 32'd1024) begin
            if (m == 2'b10) begin
                e.sel = 3'b100; e.ofs = a[18:0];
            end else if (w) begin
                e.err = 1'b1;
            end else begin
                e.sel = (m == 2'b01) ? 3'b010 : 3'b001; e.ofs = a[18:0];
            end
        end else if (a >= 32'h0800_0000 && a < 32'h0808_0000) begin
            e.sel = 3'b001; e.ofs = 19'(a - 32'h0800_0000);
        end else if (a >= 32'h0808_0000 && a < 32'h0810_0000) begin
            e.sel = 3'b010; e.ofs = 19'(a - 32'h0808_0000);
        end else if (a >= 32'h2000_0000 && a < 32'h2008_0000) begin
            e.sel = 3'b100; e.ofs = 19'(a - 32'h2000_0000);
        end else begin
            e.err = 1'b1;
        end
        return e;
    endfunction

    task automatic step(input logic v, input logic [31:0] a, input logic w,
                        input logic we, input logic [1:0] wd, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = v; req_addr = a; req_write = w;
        map_wr_en = we; map_wr_data = wd;
        e = predict(v, a, w, model_map);
        if (we && wd != 2'b11) model_map = wd;
        e.map = model_map;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    always @(posedge clk) begin
        #5;
        if (!rst && exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (rsp_valid !== e.v || tgt_sel !== e.sel || tgt_offset !== e.ofs ||
                rsp_err !== e.err || map_rd_data !== e.map) begin
                n_fail++;
                $display("FAIL %s: got v=%0b sel=%b ofs=%h err=%0b map=%b, expected v=%0b sel=%b ofs=%h err=%0b map=%b",
                         t, rsp_valid, tgt_sel, tgt_offset, rsp_err, map_rd_data,
                         e.v, e.sel, e.ofs, e.err, e.map);
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (map_rd_data !== 2'b00 || rsp_valid !== 1'b0 || tgt_sel !== 3'b000 || rsp_err !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: got map=%b v=%0b sel=%b err=%0b, expected 00 0 000 0",
                     map_rd_data, rsp_valid, tgt_sel, rsp_err);
        end
        rst = 1'b0;

        step(1, 32'h0000_0004, 0, 0, 2'b00, "R2 alias read boot");
        step(1, 32'h0000_0000, 0, 0, 2'b00, "R2 stack pointer word");
        step(1, 32'h0000_03FC, 0, 0, 2'b00, "R10 last window word");
        step(1, 32'h0000_0400, 0, 0, 2'b00, "R10 first word past window");
        step(1, 32'h0000_0010, 1, 0, 2'b00, "R7 alias write to boot flash");
        step(0, 32'h0000_0010, 0, 0, 2'b00, "R11 idle cycle");
        step(1, 32'h0800_0010, 0, 0, 2'b00, "R6 native boot");
        step(1, 32'h0807_FFFC, 0, 0, 2'b00, "R6 boot last word");
        step(1, 32'h0808_1234, 1, 0, 2'b00, "R6 native second bank");
        step(1, 32'h2000_0100, 1, 0, 2'b00, "R6 native sram write");
        step(1, 32'h1000_0000, 0, 0, 2'b00, "R8 unmapped");
        step(1, 32'h2008_0000, 0, 0, 2'b00, "R8 past sram");
        // map change with a request in the same cycle: old mapping applies
        step(1, 32'h0000_0008, 0, 1, 2'b01, "R9 request alongside map write");
        step(1, 32'h0000_0008, 0, 0, 2'b00, "R3 alias read second bank");
        step(1, 32'h0000_0020, 1, 0, 2'b00, "R7 alias write to second bank");
        step(0, 32'h0, 0, 1, 2'b11, "R5 reserved write");
        step(1, 32'h0000_000C, 0, 0, 2'b00, "R5 routing unchanged after reserved");
        step(1, 32'h0000_0030, 0, 1, 2'b10, "R9 switch to sram");
        step(1, 32'h0000_0030, 1, 0, 2'b00, "R4 alias write sram");
        step(1, 32'h0000_03FC, 0, 0, 2'b00, "R4 alias read sram");
        step(1, 32'h0800_0040, 0, 0, 2'b00, "R6 native boot under sram map");
        step(1, 32'h0808_0000, 1, 0, 2'b00, "R6 second bank base under sram map");
        step(1, 32'h0000_0004, 0, 1, 2'b00, "R9 switch back to boot");
        step(1, 32'h0000_0004, 0, 0, 2'b00, "R2 alias boot again");
        step(0, 32'h0, 0, 0, 2'b00, "R11 idle tail");
        step(0, 32'h0, 0, 0, 2'b00, "R11 idle tail");
        repeat (3) @(posedge clk);
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R9: got %0d unanswered items, expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule